// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Slice

This block is a pipelined arithmetic slice. A signed 18 x 18 multiplier and three operand selectors (X, Y and Z) feed one three-input 48-bit adder/subtracter, which always forms Z + (X + Y + cin) or Z - (X + Y + cin). A 7-bit mode word picks the source of each adder operand. The same datapath can therefore act as a plain adder, a loadable register, a multiplier, an accumulator or a multiply-accumulate unit. The 48-bit result register P feeds back into the selectors, so accumulation needs no outside help.

Operands A and B pass through zero, one or two input registers, set by parameters. C and the control word (mode, subtract, carry-in) pass through zero or one. Each group has its own clock enable. The result register has one as well. There is no valid/ready handshake. Data moves one stage at every clock whose enable is high, and a low enable stalls that stage in place. The caller holds back-pressure by dropping enables. A synchronous reset clears every register in the slice.

Top module: `mac_slice`

## Requirements
- R1: The multiplier treats A and B as two's-complement 18-bit values. With mode 7'b0000101, P receives A x B as a 36-bit product sign-extended to 48 bits. Examples: -3 x 5 gives 48'hFFFF_FFFF_FFF1, and (-2^17) x (-2^17) gives 2^34.
- R2: The adder computes Z + (X + Y + cin) when sub = 0 and Z - (X + Y + cin) when sub = 1. The carry-in is always added to X + Y, never to Z. With mode 7'b0100101, C = 100, A = 3, B = 4 and cin = 1, P is 87 when subtracting and 113 when adding.
- R3: Mode bits [1:0] select X: 0 gives zero, 1 gives the product, 2 gives P, and 3 gives the 36-bit concatenation {A,B} (A in the upper 18 bits) sign-extended to 48 bits.
- R4: Mode bits [3:2] select Y: 0 gives zero, 1 gives the multiplier's second path (zero, because the full product travels on X), 2 gives C, and 3 is reserved and gives zero.
- R5: Mode bits [6:4] select Z: 0 gives zero, 1 gives P, 2 gives C, and codes 3 to 7 give zero.
- R6: The op_bad output is registered with P. It is 1 when exactly one of X and Y selects the multiplier, when Y uses code 3, or when Z uses a code above 2. Otherwise it is 0.
- R7: The A and B inputs reach P after AREG+1 and BREG+1 enabled clocks. C reaches P after CREG+1, and the control word after CTRLREG+1. AREG and BREG may each be 0, 1 or 2. CREG and CTRLREG may each be 0 or 1.
- R8: A stage whose clock enable is low holds its value. While ce_p is low, P, ovf and op_bad do not change.
- R9: While rst is high at a clock edge, every register clears. P, ovf and op_bad read 0 after that edge.
- R10: The result wraps modulo 2^48 with no saturation. The ovf output is 1 exactly when the true signed result lies outside [-2^47, 2^47-1].
- R11: Starting from zero, accumulating the full-scale product 2^34 4096 times yields exactly 2^46 with ovf = 0. The 8192nd accumulation wraps P to 48'h8000_0000_0000 with ovf = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears all registers |
| ce_a | input | 1 | Clock enable of the A input registers |
| ce_b | input | 1 | Clock enable of the B input registers |
| ce_c | input | 1 | Clock enable of the C input register |
| ce_ctrl | input | 1 | Clock enable of the control register (mode, sub, cin) |
| ce_p | input | 1 | Clock enable of the result and flag registers |
| a | input | 18 | Signed operand A |
| b | input | 18 | Signed operand B |
| c | input | 48 | 48-bit operand C |
| cin | input | 1 | Carry-in, added to X + Y |
| sub | input | 1 | 1 subtracts (X + Y + cin) from Z, 0 adds it |
| opmode | input | 7 | Selector word: [1:0] X, [3:2] Y, [6:4] Z |
| p | output | 48 | Registered result |
| ovf | output | 1 | Registered signed overflow of the last update |
| op_bad | output | 1 | Registered flag for an illegal selector combination |

## Verification
A corrupted input pipeline register appears on P exactly as many enabled clocks after the fault as that stage lies from the result, so a stall that is ignored, or a stage that is added or dropped, shows up within two or three cycles. A wrong value in P itself is worse whenever Z or X selects feedback: the error carries into every following result until a reset or a non-feedback mode. In the long accumulation run it shows up as a wrong final total or as an overflow flag that fires early or late. Selector or flag decoding errors show up on the very next enabled update, because op_bad and ovf are registered together with P.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;
  localparam int OPW     = 18;
  localparam int PW      = 48;
  localparam int PRODW   = 2 * OPW;
  localparam int OPMODEW = 7;

  localparam logic [1:0] XS_ZERO = 2'd0;
  localparam logic [1:0] XS_PROD = 2'd1;
  localparam logic [1:0] XS_P    = 2'd2;
  localparam logic [1:0] XS_AB   = 2'd3;

  localparam logic [1:0] YS_ZERO = 2'd0;
  localparam logic [1:0] YS_PROD = 2'd1;
  localparam logic [1:0] YS_C    = 2'd2;
  localparam logic [1:0] YS_RSV  = 2'd3;

  localparam logic [2:0] ZS_ZERO = 3'd0;
  localparam logic [2:0] ZS_P    = 3'd1;
  localparam logic [2:0] ZS_C    = 3'd2;

  typedef struct packed {
    logic [2:0] z;
    logic [1:0] y;
    logic [1:0] x;
  } opmode_t;

  typedef struct packed {
    opmode_t op;
    logic    sub;
    logic    cin;
  } ctrl_t;
endpackage

// File: rtl/mac_pipe.sv
module mac_pipe #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_thru
      logic unused_pins;
      assign unused_pins = clk ^ rst ^ en;
      assign q = d;
    end else begin : g_reg
      logic [W-1:0] st [DEPTH];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) st[i] <= '0;
        end else if (en) begin
          st[0] <= d;
          for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
        end
      end

      assign q = st[DEPTH-1];

      // R8
      stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));

      if (DEPTH == 1) begin : g_one
        // R7
        stage_latency_chk: assert property (@(posedge clk) disable iff (rst)
          en |=> (q == $past(d)));
      end
    end
  endgenerate
endmodule

// File: rtl/mac_xyz_mux.sv
module mac_xyz_mux
  import mac_slice_pkg::*;
(
  input  opmode_t                op,
  input  logic signed [PRODW-1:0] prod,
  input  logic [PW-1:0]          p,
  input  logic [PW-1:0]          c,
  input  logic [OPW-1:0]         a,
  input  logic [OPW-1:0]         b,
  output logic [PW-1:0]          x,
  output logic [PW-1:0]          y,
  output logic [PW-1:0]          z,
  output logic                   bad
);
  localparam int EXT = PW - PRODW;

  logic [PRODW-1:0] ab;
  assign ab = {a, b};

  always_comb begin
    unique case (op.x)
      XS_ZERO: x = '0;
      XS_PROD: x = {{EXT{prod[PRODW-1]}}, prod};
      XS_P:    x = p;
      default: x = {{EXT{ab[PRODW-1]}}, ab};
    endcase
  end

  always_comb begin
    unique case (op.y)
      YS_C:    y = c;
      default: y = '0;
    endcase
  end

  always_comb begin
    unique case (op.z)
      ZS_P:    z = p;
      ZS_C:    z = c;
      default: z = '0;
    endcase
  end

  assign bad = ((op.x == XS_PROD) != (op.y == YS_PROD)) ||
               (op.y == YS_RSV) || (op.z > ZS_C);
endmodule

// File: rtl/mac_addsub.sv
module mac_addsub
  import mac_slice_pkg::*;
(
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  input  logic [PW-1:0] z,
  input  logic          cin,
  input  logic          sub,
  output logic [PW-1:0] res,
  output logic          ovf
);
  localparam int EW = PW + 2;

  logic [EW-1:0] xe, ye, ze, s, r;

  assign xe = {{2{x[PW-1]}}, x};
  assign ye = {{2{y[PW-1]}}, y};
  assign ze = {{2{z[PW-1]}}, z};
  assign s  = xe + ye + {{(EW-1){1'b0}}, cin};
  assign r  = sub ? (ze - s) : (ze + s);

  assign res = r[PW-1:0];
  assign ovf = !((r[EW-1] == r[EW-2]) && (r[EW-2] == r[PW-1]));
endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_slice_pkg::*;
#(
  parameter int AREG    = 1,
  parameter int BREG    = 1,
  parameter int CREG    = 1,
  parameter int CTRLREG = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce_a,
  input  logic               ce_b,
  input  logic               ce_c,
  input  logic               ce_ctrl,
  input  logic               ce_p,
  input  logic [OPW-1:0]     a,
  input  logic [OPW-1:0]     b,
  input  logic [PW-1:0]      c,
  input  logic               cin,
  input  logic               sub,
  input  logic [OPMODEW-1:0] opmode,
  output logic [PW-1:0]      p,
  output logic               ovf,
  output logic               op_bad
);
  localparam int CTLW = $bits(ctrl_t);
  localparam logic signed [PRODW-1:0] PROD_MAX = PRODW'(1) << (PRODW - 2);

  logic [OPW-1:0]          a_s, b_s;
  logic [PW-1:0]           c_s;
  ctrl_t                   ctl_in, ctl_s;
  logic signed [PRODW-1:0] prod;
  logic [PW-1:0]           x, y, z, sum;
  logic                    ovf_n, bad_n;

  assign ctl_in = '{op: opmode_t'(opmode), sub: sub, cin: cin};

  mac_pipe #(.W(OPW), .DEPTH(AREG)) u_apipe (
    .clk(clk), .rst(rst), .en(ce_a), .d(a), .q(a_s));

  mac_pipe #(.W(OPW), .DEPTH(BREG)) u_bpipe (
    .clk(clk), .rst(rst), .en(ce_b), .d(b), .q(b_s));

  mac_pipe #(.W(PW), .DEPTH(CREG)) u_cpipe (
    .clk(clk), .rst(rst), .en(ce_c), .d(c), .q(c_s));

  mac_pipe #(.W(CTLW), .DEPTH(CTRLREG)) u_kpipe (
    .clk(clk), .rst(rst), .en(ce_ctrl), .d(ctl_in), .q(ctl_s));

  assign prod = $signed(a_s) * $signed(b_s);

  // R1
  prod_range_chk: assert property (@(posedge clk) disable iff (rst)
    (prod <= PROD_MAX) && (prod > -PROD_MAX));

  mac_xyz_mux u_mux (
    .op(ctl_s.op), .prod(prod), .p(p), .c(c_s), .a(a_s), .b(b_s),
    .x(x), .y(y), .z(z), .bad(bad_n));

  mac_addsub u_add (
    .x(x), .y(y), .z(z), .cin(ctl_s.cin), .sub(ctl_s.sub),
    .res(sum), .ovf(ovf_n));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_s.sub && !ctl_s.cin && (y == '0) && (z == '0)) |-> !ovf_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      p      <= '0;
      ovf    <= 1'b0;
      op_bad <= 1'b0;
    end else if (ce_p) begin
      p      <= sum;
      ovf    <= ovf_n;
      op_bad <= bad_n;
    end
  end

  // R8
  p_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ce_p |=> ($stable(p) && $stable(ovf) && $stable(op_bad)));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> ((p == '0) && !ovf && !op_bad));
endmodule

// File: tb/mac_slice_test.sv
module mac_ref #(
  parameter int AREG    = 1,
  parameter int BREG    = 1,
  parameter int CREG    = 1,
  parameter int CTRLREG = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ce_a,
  input  logic        ce_b,
  input  logic        ce_c,
  input  logic        ce_ctrl,
  input  logic        ce_p,
  input  logic [17:0] a,
  input  logic [17:0] b,
  input  logic [47:0] c,
  input  logic        cin,
  input  logic        sub,
  input  logic [6:0]  op,
  output logic [47:0] p,
  output logic        ovf,
  output logic        bad
);
  logic [17:0] ah0, ah1, bh0, bh1, ae, be;
  logic [47:0] ch, ce;
  logic [6:0]  oph, ope;
  logic        subh, cinh, sube, cine;
  longint      xv, yv, zv, sv, rv;
  logic [35:0] abv;
  logic [47:0] p_n;
  logic        ovf_n, bad_n;

  always_comb begin
    ae   = (AREG == 0) ? a : ((AREG == 1) ? ah0 : ah1);
    be   = (BREG == 0) ? b : ((BREG == 1) ? bh0 : bh1);
    ce   = (CREG == 0) ? c : ch;
    ope  = (CTRLREG == 0) ? op : oph;
    sube = (CTRLREG == 0) ? sub : subh;
    cine = (CTRLREG == 0) ? cin : cinh;
    abv  = {ae, be};
    case (ope[1:0])
      2'd0: xv = 0;
      2'd1: xv = longint'($signed(ae)) * longint'($signed(be));
      2'd2: xv = longint'($signed(p));
      default: xv = longint'($signed(abv));
    endcase
    yv = (ope[3:2] == 2'd2) ? longint'($signed(ce)) : 0;
    case (ope[6:4])
      3'd1: zv = longint'($signed(p));
      3'd2: zv = longint'($signed(ce));
      default: zv = 0;
    endcase
    sv = xv + yv + longint'(cine);
    rv = sube ? (zv - sv) : (zv + sv);
    p_n   = rv[47:0];
    ovf_n = (rv > 64'sd140737488355327) || (rv < -64'sd140737488355328);
    bad_n = ((ope[1:0] == 2'd1) != (ope[3:2] == 2'd1)) ||
            (ope[3:2] == 2'd3) || (ope[6:4] > 3'd2);
  end

  always @(posedge clk) begin
    if (rst) begin
      ah0 <= '0; ah1 <= '0; bh0 <= '0; bh1 <= '0; ch <= '0;
      oph <= '0; subh <= 1'b0; cinh <= 1'b0;
      p <= '0; ovf <= 1'b0; bad <= 1'b0;
    end else begin
      if (ce_a) begin ah0 <= a; ah1 <= ah0; end
      if (ce_b) begin bh0 <= b; bh1 <= bh0; end
      if (ce_c) ch <= c;
      if (ce_ctrl) begin oph <= op; subh <= sub; cinh <= cin; end
      if (ce_p) begin p <= p_n; ovf <= ovf_n; bad <= bad_n; end
    end
  end
endmodule

module mac_slice_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst = 1'b1;
  logic        ce_a = 1'b1, ce_b = 1'b1, ce_c = 1'b1, ce_ctrl = 1'b1, ce_p = 1'b1;
  logic [17:0] a = '0, b = '0;
  logic [47:0] c = '0;
  logic        cin = 1'b0, sub = 1'b0;
  logic [6:0]  opmode = '0;

  logic [47:0] dp [3];
  logic [47:0] rp [3];
  logic        dovf [3], rovf [3], dbad [3], rbad [3];

  int    errs = 0;
  int    checks = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string tag = "R9";

  mac_slice #(.AREG(1), .BREG(1), .CREG(1), .CTRLREG(1)) uut (
    .clk(clk), .rst(rst), .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c), .ce_ctrl(ce_ctrl),
    .ce_p(ce_p), .a(a), .b(b), .c(c), .cin(cin), .sub(sub), .opmode(opmode),
    .p(dp[0]), .ovf(dovf[0]), .op_bad(dbad[0]));
  mac_ref #(.AREG(1), .BREG(1), .CREG(1), .CTRLREG(1)) ref0 (
    .clk(clk), .rst(rst), .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c), .ce_ctrl(ce_ctrl),
    .ce_p(ce_p), .a(a), .b(b), .c(c), .cin(cin), .sub(sub), .op(opmode),
    .p(rp[0]), .ovf(rovf[0]), .bad(rbad[0]));

  mac_slice #(.AREG(0), .BREG(0), .CREG(0), .CTRLREG(0)) uut_z (
    .clk(clk), .rst(rst), .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c), .ce_ctrl(ce_ctrl),
    .ce_p(ce_p), .a(a), .b(b), .c(c), .cin(cin), .sub(sub), .opmode(opmode),
    .p(dp[1]), .ovf(dovf[1]), .op_bad(dbad[1]));
  mac_ref #(.AREG(0), .BREG(0), .CREG(0), .CTRLREG(0)) ref1 (
    .clk(clk), .rst(rst), .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c), .ce_ctrl(ce_ctrl),
    .ce_p(ce_p), .a(a), .b(b), .c(c), .cin(cin), .sub(sub), .op(opmode),
    .p(rp[1]), .ovf(rovf[1]), .bad(rbad[1]));

  mac_slice #(.AREG(2), .BREG(2), .CREG(1), .CTRLREG(0)) uut_d (
    .clk(clk), .rst(rst), .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c), .ce_ctrl(ce_ctrl),
    .ce_p(ce_p), .a(a), .b(b), .c(c), .cin(cin), .sub(sub), .opmode(opmode),
    .p(dp[2]), .ovf(dovf[2]), .op_bad(dbad[2]));
  mac_ref #(.AREG(2), .BREG(2), .CREG(1), .CTRLREG(0)) ref2 (
    .clk(clk), .rst(rst), .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c), .ce_ctrl(ce_ctrl),
    .ce_p(ce_p), .a(a), .b(b), .c(c), .cin(cin), .sub(sub), .op(opmode),
    .p(rp[2]), .ovf(rovf[2]), .bad(rbad[2]));

  task automatic expect48(string req, string what, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      for (int i = 0; i < 3; i++) begin
        expect48(tag, $sformatf("inst%0d p", i), dp[i], rp[i]);
        expect48(tag, $sformatf("inst%0d ovf", i), 48'(dovf[i]), 48'(rovf[i]));
        expect48(tag, $sformatf("inst%0d op_bad", i), 48'(dbad[i]), 48'(rbad[i]));
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    tick(2);
    // R9: reset state on all three configurations
    for (int i = 0; i < 3; i++) begin
      expect48("R9", "reset p", dp[i], 48'h0);
      expect48("R9", "reset ovf", 48'(dovf[i]), 48'h0);
      expect48("R9", "reset op_bad", 48'(dbad[i]), 48'h0);
    end
    cmp_on = 1'b1;
    rst = 1'b0;

    // R1: signed product on the zero-latency slice
    tag = "R1";
    opmode = 7'b0000101; a = 18'h3FFFD; b = 18'd5;
    tick(1);
    expect48("R1", "-3*5", dp[1], 48'hFFFF_FFFF_FFF1);
    a = 18'h20000; b = 18'h20000;
    tick(1);
    expect48("R1", "min*min", dp[1], 48'h0004_0000_0000);

    // R2: subtract flips only the sign of X+Y+cin
    tag = "R2";
    opmode = 7'b0100101; c = 48'd100; a = 18'd3; b = 18'd4; cin = 1'b1; sub = 1'b1;
    tick(1);
    expect48("R2", "C-(AB+cin)", dp[1], 48'd87);
    sub = 1'b0;
    tick(1);
    expect48("R2", "C+(AB+cin)", dp[1], 48'd113);

    // R3: X selects {A,B} sign-extended
    tag = "R3";
    opmode = 7'b0000011; cin = 1'b0; a = 18'h20000; b = 18'd1;
    tick(1);
    expect48("R3", "A:B", dp[1], 48'hFFF8_0000_0001);

    // R4: Y selects C
    tag = "R4";
    opmode = 7'b0001000; c = 48'h1234_5678_9ABC;
    tick(1);
    expect48("R4", "Y=C", dp[1], 48'h1234_5678_9ABC);
    expect48("R4", "Y=C legal", 48'(dbad[1]), 48'h0);

    // R5: Z selects P, cin increments
    tag = "R5";
    opmode = 7'b0010000; cin = 1'b1;
    tick(1);
    expect48("R5", "Z=P +1", dp[1], 48'h1234_5678_9ABD);

    // R6: illegal combinations
    tag = "R6";
    cin = 1'b0;
    opmode = 7'b0000001; tick(1);
    expect48("R6", "X mult without Y", 48'(dbad[1]), 48'h1);
    opmode = 7'b0110000; tick(1);
    expect48("R6", "Z code 3", 48'(dbad[1]), 48'h1);
    opmode = 7'b0001100; tick(1);
    expect48("R6", "Y code 3", 48'(dbad[1]), 48'h1);
    opmode = 7'b0000101; tick(1);
    expect48("R6", "legal mult", 48'(dbad[1]), 48'h0);

    // R8: ce_p low holds the result
    tag = "R8";
    opmode = 7'b0000011; a = 18'd7; b = 18'd9; tick(3);
    ce_p = 1'b0;
    begin
      logic [47:0] held;
      held = dp[1];
      a = 18'd1; b = 18'd2; opmode = 7'b0100011; c = 48'd55;
      tick(3);
      expect48("R8", "p held", dp[1], held);
    end
    ce_p = 1'b1;

    // R7: two-stage A/B latency on uut_d
    tag = "R7";
    opmode = 7'b0000011; a = '0; b = '0; c = '0; sub = 1'b0; cin = 1'b0;
    tick(4);
    a = 18'd1; b = 18'd2;
    tick(2);
    expect48("R7", "after 2 edges", dp[2], 48'h0);
    tick(1);
    expect48("R7", "after 3 edges", dp[2], 48'h0_0004_0002);

    // R3 R4 R5 R6 R7 R8: sweep every mode with both subtract settings
    tag = "R3/R4/R5/R6/R7/R8 sweep";
    for (int m = 0; m < 128; m++) begin
      for (int s = 0; s < 2; s++) begin
        opmode = 7'(m); sub = s[0];
        a = 18'($urandom); b = 18'($urandom);
        c = {16'($urandom), 32'($urandom)}; cin = 1'($urandom);
        ce_a = ($urandom % 4) != 0; ce_b = ($urandom % 4) != 0;
        ce_c = ($urandom % 4) != 0; ce_ctrl = ($urandom % 4) != 0;
        ce_p = ($urandom % 4) != 0;
        tick(1);
      end
    end
    tag = "R2/R10 random";
    for (int k = 0; k < 300; k++) begin
      opmode = 7'($urandom); sub = 1'($urandom);
      a = 18'($urandom); b = 18'($urandom);
      c = {16'($urandom), 32'($urandom)}; cin = 1'($urandom);
      ce_a = ($urandom % 4) != 0; ce_b = ($urandom % 4) != 0;
      ce_c = ($urandom % 4) != 0; ce_ctrl = ($urandom % 4) != 0;
      ce_p = ($urandom % 4) != 0;
      tick(1);
    end

    // R9: reset in mid-run
    tag = "R9";
    ce_a = 1'b1; ce_b = 1'b1; ce_c = 1'b1; ce_ctrl = 1'b1; ce_p = 1'b1;
    rst = 1'b1;
    tick(1);
    for (int i = 0; i < 3; i++) begin
      expect48("R9", "mid-run reset p", dp[i], 48'h0);
      expect48("R9", "mid-run reset ovf", 48'(dovf[i]), 48'h0);
    end

    // R11 and R10: long full-scale accumulation
    tag = "R11";
    a = 18'h20000; b = 18'h20000; opmode = 7'b0010101; sub = 1'b0; cin = 1'b0;
    tick(1);
    rst = 1'b0;
    tick(4096);
    expect48("R11", "4096 accumulations", dp[1], 48'h4000_0000_0000);
    expect48("R11", "no overflow yet", 48'(dovf[1]), 48'h0);
    tag = "R10";
    tick(4096);
    expect48("R10", "wrap at 8192", dp[1], 48'h8000_0000_0000);
    expect48("R10", "overflow flag", 48'(dovf[1]), 48'h1);
    tick(4);

    cmp_on = 1'b0;
    finish_run();
  end
endmodule